// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Port

This block gives software direct, bit-level control of an external three-wire serial EEPROM through a single 8-bit control register. The EEPROM pins sit behind a memory port that another requester also uses. Software first sets a request bit. The block waits until the other requester is not busy, then takes the port and raises a ready bit. There is no fixed delay before this grant.

Once the port is owned, three register bits drive the EEPROM chip select, serial clock and serial data pins directly. The EEPROM's serial output is synchronised and read back in bit 0. Every later register write that keeps the request bit set drops the ready bit. Ready then returns high after a settle interval of about 800 ns, counted in clock cycles. Software polls ready as a pacing timer between clock edges. The EEPROM command protocol is handled entirely by software.

Two more bits carry a plain external arbitration handshake. One is an output request. The other is a synchronised acknowledge input.

Top module: `eeport_top`

## Requirements
- R1: After reset, the register reads 0x00 and `ee_cs`, `ee_sk`, `ee_di` and `ext_req` are all low.
- R2: The register fields are: bit 5 port request, bit 3 chip select, bit 2 serial clock, bit 1 serial data out. The written values of these bits read back from the cycle after a write.
- R3: The port is granted only at a clock edge where `port_busy` is low and the request bit is set. While `port_busy` stays high, ready (bit 4) stays low. Ready rises in the cycle after the grant edge.
- R4: Until the port is granted, `ee_cs`, `ee_sk` and `ee_di` stay low, whatever values bits 3..1 hold.
- R5: While the port is owned, `ee_cs`, `ee_sk` and `ee_di` equal register bits 3, 2 and 1 from the cycle after the write that set them.
- R6: Bit 0 reads `ee_do` through a two-stage synchroniser: a level applied just after an edge shows in bit 0 after the second following edge. Bit 0 reads 0 while the port is not owned.
- R7: A write with bit 5 set, made while the port is owned, holds ready low for SETTLE_CYC cycles (80 at 100 MHz) and then raises it. A further such write restarts the full interval.
- R8: Writing bit 5 as 0 releases the port. From the next cycle, ready and the three EEPROM outputs are low. A new request must win arbitration again.
- R9: `ext_req` follows register bit 6 from the cycle after a write. Bit 7 reads `ext_ack` after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read view |
| port_busy | input | 1 | Other requester is using the shared port |
| ext_ack | input | 1 | External arbitration acknowledge (asynchronous) |
| ext_req | output | 1 | External arbitration request |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in (driven by this block) |
| ee_do | input | 1 | EEPROM serial data out (asynchronous) |

## Verification
The checkers reconstruct port ownership from the visible register alone. They assume `port_busy`, `reg_wr` and `reg_wdata` are synchronous to `clk`, and that a write strobe lasts exactly one cycle. `ee_do` and `ext_ack` may change at any time, because they only reach the register through synchronisers. The stimulus changes every input one time unit after the falling clock edge, so all of these assumptions hold. Random write data, busy patterns and EEPROM levels are mixed with directed windows for arbitration, the settle timer and release.

// File: rtl/eeport_pkg.sv
package eeport_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_DIN  = 0;
  localparam int unsigned B_DOUT = 1;
  localparam int unsigned B_SCK  = 2;
  localparam int unsigned B_CS   = 3;
  localparam int unsigned B_RDY  = 4;
  localparam int unsigned B_REQ  = 5;
  localparam int unsigned B_XREQ = 6;
  localparam int unsigned B_XACK = 7;

  typedef struct packed {
    logic xreq;
    logic req;
    logic cs;
    logic sck;
    logic dout;
  } ctl_t;
endpackage

// File: rtl/eeport_sync.sv
module eeport_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/eeport_arb.sv
module eeport_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic busy,
  output logic granted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                granted <= 1'b0;
    else if (!want)            granted <= 1'b0;
    else if (!granted && !busy) granted <= 1'b1;
  end
endmodule

// File: rtl/eeport_timer.sv
module eeport_timer #(
  parameter int unsigned CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= LOADV;
    else if (!active)      cnt <= '0;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/eeport_top.sv
module eeport_top #(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned SETTLE_NS   = 800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       port_busy,
  input  logic       ext_ack,
  output logic       ext_req,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do
);
  import eeport_pkg::*;

  localparam int unsigned RAW_CYC    = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  ctl_t       ctl_q;
  logic       granted;
  logic       owned;
  logic       settled;
  logic       restart;
  logic [1:0] sync_in;
  logic [1:0] sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (reg_wr) begin
      ctl_q.xreq <= reg_wdata[B_XREQ];
      ctl_q.req  <= reg_wdata[B_REQ];
      ctl_q.cs   <= reg_wdata[B_CS];
      ctl_q.sck  <= reg_wdata[B_SCK];
      ctl_q.dout <= reg_wdata[B_DOUT];
    end
  end

  eeport_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .want    (ctl_q.req),
    .busy    (port_busy),
    .granted (granted)
  );

  assign owned   = granted & ctl_q.req;
  assign restart = reg_wr & reg_wdata[B_REQ] & owned;

  eeport_timer #(.CYC(SETTLE_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (owned),
    .restart (restart),
    .expired (settled)
  );

  assign sync_in = {ext_ack, ee_do};

  eeport_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_in),
    .q     (sync_out)
  );

  assign ee_cs   = owned & ctl_q.cs;
  assign ee_sk   = owned & ctl_q.sck;
  assign ee_di   = owned & ctl_q.dout;
  assign ext_req = ctl_q.xreq;

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_XACK] = sync_out[1];
    reg_rdata[B_XREQ] = ctl_q.xreq;
    reg_rdata[B_REQ]  = ctl_q.req;
    reg_rdata[B_RDY]  = owned & settled;
    reg_rdata[B_CS]   = ctl_q.cs;
    reg_rdata[B_SCK]  = ctl_q.sck;
    reg_rdata[B_DOUT] = ctl_q.dout;
    reg_rdata[B_DIN]  = owned & sync_out[0];
  end
endmodule

// File: rtl/eeport_chk.sv
module eeport_chk #(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned SETTLE_NS = 800
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       port_busy,
  input logic       ext_req,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di
);
  localparam int unsigned RAW    = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned SETTLE = (RAW < 1) ? 1 : RAW;

  logic        own_seen;
  int unsigned lo_cnt;
  logic        rdy, reqb, own_now;

  assign rdy     = reg_rdata[4];
  assign reqb    = reg_rdata[5];
  assign own_now = own_seen | rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_seen <= 1'b0;
      lo_cnt   <= 0;
    end else begin
      own_seen <= reqb ? own_now : 1'b0;
      if (reg_wr && reg_wdata[5] && own_now && reqb) lo_cnt <= SETTLE;
      else if (!reqb)                                lo_cnt <= 0;
      else if (lo_cnt != 0)                          lo_cnt <= lo_cnt - 1;
    end
  end

  // R3
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdy) && !$past(own_seen)) |-> !$past(port_busy));

  // R4
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !own_now |-> (!ee_cs && !ee_sk && !ee_di && !reg_rdata[0]));

  // R5
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[5] && reqb && own_now) |=>
      (ee_cs == $past(reg_wdata[3]) && ee_sk == $past(reg_wdata[2]) && ee_di == $past(reg_wdata[1])));

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt != 0) |-> !rdy);

  // R7
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt == 1 && reqb && !reg_wr) |=> rdy);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[5]) |=> (!rdy && !ee_cs && !ee_sk && !ee_di));

  // R9
  ext_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (ext_req == $past(reg_wdata[6])));
endmodule

bind eeport_top eeport_chk #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .port_busy (port_busy),
  .ext_req   (ext_req),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di)
);

// File: tb/sim_eeport_top.sv
module sim_eeport_top;
  localparam int SETTLE = (800 * 100 + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       port_busy = 1'b0;
  logic       ext_ack = 1'b0;
  logic       ext_req;
  logic       ee_cs, ee_sk, ee_di;
  logic       ee_do = 1'b0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  eeport_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_busy(port_busy), .ext_ack(ext_ack),
    .ext_req(ext_req), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // behavioural reference
  bit m_req, m_cs, m_sck, m_dout, m_xreq, m_grant;
  int m_tmr;
  bit do_q[$]  = '{1'b0, 1'b0};
  bit ack_q[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_cs = 0; m_sck = 0; m_dout = 0; m_xreq = 0; m_grant = 0; m_tmr = 0;
      do_q = '{1'b0, 1'b0};
      ack_q = '{1'b0, 1'b0};
    end else begin
      bit was_owned;
      bit ng;
      was_owned = m_grant && m_req;
      ng = m_grant;
      if (!m_req) ng = 0;
      else if (!m_grant && !port_busy) ng = 1;
      if (reg_wr && reg_wdata[5] && was_owned) m_tmr = SETTLE;
      else if (!was_owned) m_tmr = 0;
      else if (m_tmr > 0) m_tmr = m_tmr - 1;
      m_grant = ng;
      if (reg_wr) begin
        m_xreq = reg_wdata[6]; m_req = reg_wdata[5]; m_cs = reg_wdata[3];
        m_sck = reg_wdata[2]; m_dout = reg_wdata[1];
      end
      do_q.push_back(ee_do);   void'(do_q.pop_front());
      ack_q.push_back(ext_ack); void'(ack_q.pop_front());
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit own;
      own = m_grant && m_req;
      chk("R7 ready bit", reg_rdata[4], own && m_tmr == 0);
      chk("R6 data-in bit", reg_rdata[0], own && do_q[0]);
      chk("R9 ack/req bits", reg_rdata[7:6], {ack_q[0], m_xreq});
      chk("R2 control bits", {reg_rdata[5], reg_rdata[3:1]}, {m_req, m_cs, m_sck, m_dout});
      chk("R5 EEPROM pins", {ee_cs, ee_sk, ee_di}, {own && m_cs, own && m_sck, own && m_dout});
      chk("R9 ext_req pin", ext_req, m_xreq);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [7:0] d);
    step(); reg_wr = 1'b1; reg_wdata = d;
    step(); reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] lf;
    repeat (3) step();
    // R1: reset state
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R1 reset pins", {ee_cs, ee_sk, ee_di, ext_req}, 4'b0000);
    rst_n = 1'b1;
    step();

    // R3/R4: request while busy, with pin bits set
    port_busy = 1'b1;
    wr(8'h2E);
    repeat (5) step();
    chk("R3 no grant while busy", reg_rdata[4], 0);
    chk("R4 pins held low", {ee_cs, ee_sk, ee_di}, 3'b000);
    port_busy = 1'b0;
    step();
    chk("R3 ready after grant", reg_rdata[4], 1);
    chk("R5 pins after grant", {ee_cs, ee_sk, ee_di}, 3'b111);

    // R6: synchroniser latency
    ee_do = 1'b1;
    step();
    chk("R6 one edge, not yet", reg_rdata[0], 0);
    step();
    chk("R6 two edges, visible", reg_rdata[0], 1);

    // R7: settle interval length
    wr(8'h28);
    n = 1;
    while (!reg_rdata[4] && n < 1000) begin step(); if (!reg_rdata[4]) n++; end
    chk("R7 settle length", n, SETTLE);
    chk("R5 cs only", {ee_cs, ee_sk, ee_di}, 3'b100);

    // R7: restart in mid interval
    wr(8'h2C);
    repeat (30) step();
    wr(8'h28);
    n = 1;
    while (!reg_rdata[4] && n < 1000) begin step(); if (!reg_rdata[4]) n++; end
    chk("R7 restarted length", n, SETTLE);

    // R8: release
    wr(8'h0E);
    chk("R8 released ready", reg_rdata[4], 0);
    chk("R8 released pins", {ee_cs, ee_sk, ee_di}, 3'b000);
    port_busy = 1'b1;
    wr(8'h20);
    repeat (3) step();
    chk("R8 needs new grant", reg_rdata[4], 0);
    port_busy = 1'b0;

    // R9: external handshake bits
    wr(8'h40);
    chk("R9 ext_req set", ext_req, 1);
    ext_ack = 1'b1;
    step(); step();
    chk("R9 ack visible", reg_rdata[7], 1);

    // mixed random traffic compared against the model every cycle
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      port_busy = lf[0] & lf[3];
      ee_do = lf[5];
      ext_ack = lf[9];
      if (lf[2:0] == 3'b101) begin
        reg_wr = 1'b1;
        reg_wdata = {lf[15:14], (lf[11:8] != 4'h0), lf[7:3]};
      end else begin
        reg_wr = 1'b0;
      end
      step();
    end
    reg_wr = 1'b0;
    step();
    finish_run();
  end
endmodule